// File: doc/BRIEF.md
# Three-Wire Serial Channel Register Writer

This block receives write-only register frames over a three-wire serial link made of an active-low select, a serial clock and a serial data line. All three pins are sampled by a fast system clock and passed through a multi-stage synchroniser. Edges of the select and serial clock are then detected inside the system clock domain, so the block needs no second clock tree.

A frame carries a 4-bit address followed by 8 data bits, both sent most significant bit first. While select is low, each rising edge of the serial clock shifts in one bit. When select returns high, the frame is committed only if exactly 12 rising edges were counted and the address names one of the channel registers. On a commit, the addressed 8-bit channel register takes the data, and the strobe for that channel pulses for one system cycle. Frames of any other length are dropped, as are frames that name an unmapped address.

Top module: `serial_chan_writer`

## Requirements
- R1: After reset, every channel register reads 0 and every update strobe is low.
- R2: A 12-bit frame is taken as bits 11..8 = address and bits 7..0 = data, each sent most significant bit first. Address values 0 to 3 select channels 0 to 3, and the data is written to that channel.
- R3: A commit happens only on the rising edge of select. The value and the one-cycle strobe `ch_update[n]` of the addressed channel change at the third system clock edge after the select pin rises. The strobe is low on the cycle before and the cycle after.
- R4: A frame with fewer than 12 serial clock rising edges (0, 1 or 11 tested) changes no register and raises no strobe.
- R5: A frame with more than 12 rising edges (13 or 28 tested) changes no register and raises no strobe. The bit counter saturates at 13, so a count that would wrap back to 12 still fails.
- R6: A 12-bit frame whose address is 4 to 15 changes no register and raises no strobe.
- R7: Serial clock edges that arrive while select is high are not counted toward the next frame.
- R8: A committed write leaves every other channel register unchanged, and at most one strobe is high in any cycle.
- R9: Each low phase of select starts a fresh count, so a valid frame that follows a dropped one is committed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n_pin | input | 1 | Serial select, active low, idles high |
| sck_pin | input | 1 | Serial clock; data is sampled on its rising edge |
| sdi_pin | input | 1 | Serial data, most significant bit first |
| ch_value | output | NUM_CH*DATA_W (32) | Channel registers packed; channel n is at bits [8n+7:8n] |
| ch_update | output | NUM_CH (4) | One-cycle write strobe per channel |

## Verification
The select pin rising at a falling clock edge passes through two synchroniser flops and one registered commit. The new channel value and strobe are therefore due at the third rising system edge. Each frame task raises select at a falling edge and samples the strobes at the second, third and fourth falling edges that follow. This catches a strobe that fires early, fires late, or lasts more than one cycle. After each frame, all four channel values are compared with a model kept in the bench. Serial data is driven three system cycles before each serial clock rise, so it has settled through the synchroniser in the cycle where the rise is seen.

// File: rtl/scw_pkg.sv
package scw_pkg;
   // Counter width able to hold a frame length plus one saturation code.
   function automatic int unsigned cnt_width(input int unsigned frame_len);
      return $clog2(frame_len + 2);
   endfunction
endpackage

// File: rtl/scw_sync.sv
module scw_sync #(
   parameter int unsigned    WIDTH   = 1,
   parameter int unsigned    STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("scw_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[0] <= RST_VAL;
      else        stage_q[0] <= d;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RST_VAL;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/scw_edge.sv
module scw_edge #(
   parameter bit   RISING  = 1'b1,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig,
   output logic pulse
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= sig;
   end

   generate
      if (RISING) begin : g_rise
         assign pulse = sig & ~prev_q;
      end else begin : g_fall
         assign pulse = ~sig & prev_q;
      end
   endgenerate
endmodule

// File: rtl/scw_frame_rx.sv
module scw_frame_rx #(
   parameter int unsigned FRAME_LEN = 12,
   parameter int unsigned CNT_W     = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 active,
   input  logic                 sck_rise,
   input  logic                 sdi,
   output logic [FRAME_LEN-1:0] frame,
   output logic [CNT_W-1:0]     bit_cnt
);
   localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_LEN + 1);

   generate
      if (FRAME_LEN < 2) begin : g_bad_len
         $error("scw_frame_rx: FRAME_LEN must be at least 2");
      end
      if ((2 ** CNT_W) <= (FRAME_LEN + 1)) begin : g_bad_cnt
         $error("scw_frame_rx: CNT_W too narrow for saturation code");
      end
   endgenerate

   logic [FRAME_LEN-1:0] shift_q;
   logic [CNT_W-1:0]     cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '0;
         cnt_q   <= '0;
      end else if (!active) begin
         cnt_q   <= '0;
      end else if (sck_rise) begin
         shift_q <= {shift_q[FRAME_LEN-2:0], sdi};
         if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign frame   = shift_q;
   assign bit_cnt = cnt_q;
endmodule

// File: rtl/scw_bank.sv
module scw_bank #(
   parameter int unsigned NUM_CH    = 4,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned FRAME_LEN = ADDR_W + DATA_W,
   parameter int unsigned CNT_W     = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       commit,
   input  logic [CNT_W-1:0]           bit_cnt,
   input  logic [FRAME_LEN-1:0]       frame,
   output logic [NUM_CH*DATA_W-1:0]   ch_value,
   output logic [NUM_CH-1:0]          ch_update
);
   logic              frame_ok;
   logic [ADDR_W-1:0] addr;
   logic [DATA_W-1:0] data;

   assign frame_ok = commit && (bit_cnt == CNT_W'(FRAME_LEN));
   assign addr     = frame[FRAME_LEN-1 -: ADDR_W];
   assign data     = frame[DATA_W-1:0];

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic              hit;
         logic [DATA_W-1:0] val_q;
         logic              upd_q;

         assign hit = frame_ok && (addr == ADDR_W'(c));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               val_q <= '0;
               upd_q <= 1'b0;
            end else begin
               upd_q <= hit;
               if (hit) val_q <= data;
            end
         end

         assign ch_value[c*DATA_W +: DATA_W] = val_q;
         assign ch_update[c]                 = upd_q;
      end
   endgenerate
endmodule

// File: rtl/serial_chan_writer.sv
module serial_chan_writer #(
   parameter int unsigned NUM_CH      = 4,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sel_n_pin,
   input  logic                     sck_pin,
   input  logic                     sdi_pin,
   output logic [NUM_CH*DATA_W-1:0] ch_value,
   output logic [NUM_CH-1:0]        ch_update
);
   localparam int unsigned FRAME_LEN = ADDR_W + DATA_W;
   localparam int unsigned CNT_W     = scw_pkg::cnt_width(FRAME_LEN);

   generate
      if (NUM_CH < 1 || NUM_CH > (2 ** ADDR_W)) begin : g_bad_ch
         $error("serial_chan_writer: NUM_CH must fit the address space");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("serial_chan_writer: DATA_W must be positive");
      end
   endgenerate

   logic       sel_n_s, sck_s, sdi_s;
   logic       sel_rise, sck_rise;
   logic [FRAME_LEN-1:0] frame;
   logic [CNT_W-1:0]     bit_cnt;

   scw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({sel_n_pin, sck_pin, sdi_pin}),
      .q({sel_n_s, sck_s, sdi_s})
   );

   scw_edge #(.RISING(1'b1), .RST_VAL(1'b1)) u_sel_edge (
      .clk(clk), .rst_n(rst_n), .sig(sel_n_s), .pulse(sel_rise)
   );

   scw_edge #(.RISING(1'b1), .RST_VAL(1'b0)) u_sck_edge (
      .clk(clk), .rst_n(rst_n), .sig(sck_s), .pulse(sck_rise)
   );

   scw_frame_rx #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .active(~sel_n_s), .sck_rise(sck_rise), .sdi(sdi_s),
      .frame(frame), .bit_cnt(bit_cnt)
   );

   scw_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
              .FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .commit(sel_rise), .bit_cnt(bit_cnt), .frame(frame),
      .ch_value(ch_value), .ch_update(ch_update)
   );
endmodule

// File: rtl/scw_checker.sv
module scw_checker #(
   parameter int unsigned NUM_CH    = 4,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned FRAME_LEN = 12,
   parameter int unsigned CNT_W     = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [CNT_W-1:0]         bit_cnt,
   input logic [NUM_CH*DATA_W-1:0] ch_value,
   input logic [NUM_CH-1:0]        ch_update
);
   // R8: never more than one channel strobe at once
   assert_update_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ch_update));

   // R3: a strobe lasts a single cycle
   assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|ch_update) |=> !(|ch_update));

   // R4 / R5: registers only move together with a strobe
   assert_value_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(|ch_update) |-> $stable(ch_value));

   // R5: a strobe only follows a count of exactly the frame length
   assert_exact_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|ch_update) |-> ($past(bit_cnt) == CNT_W'(FRAME_LEN)));

   // R5: counter never passes the saturation code
   assert_cnt_saturates_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_W'(FRAME_LEN + 1));
endmodule

bind serial_chan_writer scw_checker #(
   .NUM_CH(NUM_CH), .DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bit_cnt(bit_cnt),
   .ch_value(ch_value), .ch_update(ch_update)
);

// File: tb/serial_chan_writer_tb.sv
module serial_chan_writer_tb;
   localparam int NCH = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel_n = 1'b1;
   logic sck = 1'b0;
   logic sdi = 1'b0;
   logic [NCH*8-1:0] ch_value;
   logic [NCH-1:0]   ch_update;

   int checks = 0;
   int errors = 0;
   logic [7:0] model [NCH];

   always #4 clk = ~clk;

   serial_chan_writer u_dut (
      .clk(clk), .rst_n(rst_n), .sel_n_pin(sel_n), .sck_pin(sck),
      .sdi_pin(sdi), .ch_value(ch_value), .ch_update(ch_update)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bits(input int n, input logic [31:0] w);
      for (int i = n - 1; i >= 0; i--) begin
         sdi = w[i];
         wait_cyc(3);
         sck = 1'b1;
         wait_cyc(3);
         sck = 1'b0;
         wait_cyc(2);
      end
   endtask

   task automatic check_all(input string req);
      for (int c = 0; c < NCH; c++)
         chk(req, 32'(ch_value[c*8 +: 8]), 32'(model[c]));
   endtask

   // exp_ch < 0 means no commit expected
   task automatic run_frame(input int n, input logic [31:0] w, input int exp_ch, input string req);
      logic [NCH-1:0] exp_strobe;
      exp_strobe = (exp_ch >= 0) ? NCH'(1 << exp_ch) : '0;
      sel_n = 1'b0;
      wait_cyc(4);
      send_bits(n, w);
      wait_cyc(2);
      sel_n = 1'b1;
      wait_cyc(2);
      chk({req, " R3 strobe early"}, 32'(ch_update), 32'h0);
      wait_cyc(1);
      chk({req, " R3 strobe due"}, 32'(ch_update), 32'(exp_strobe));
      if (exp_ch >= 0) model[exp_ch] = w[7:0];
      check_all({req, " R8 values"});
      wait_cyc(1);
      chk({req, " R3 strobe late"}, 32'(ch_update), 32'h0);
      wait_cyc(3);
   endtask

   task automatic t_reset_R1;
      for (int c = 0; c < NCH; c++) model[c] = 8'h00;
      check_all("R1 reset value");
      chk("R1 reset strobe", 32'(ch_update), 32'h0);
   endtask

   task automatic t_basic_R2;
      run_frame(12, {20'h0, 4'd0, 8'hA5}, 0, "R2 ch0");
      run_frame(12, {20'h0, 4'd1, 8'h3C}, 1, "R2 ch1");
      run_frame(12, {20'h0, 4'd2, 8'hFF}, 2, "R2 ch2");
      run_frame(12, {20'h0, 4'd3, 8'h81}, 3, "R2 ch3");
      run_frame(12, {20'h0, 4'd1, 8'h00}, 1, "R8 overwrite ch1");
   endtask

   task automatic t_short_R4;
      run_frame(11, {21'h0, 3'd2, 8'h55}, -1, "R4 11 bits");
      run_frame(1,  32'h1, -1, "R4 1 bit");
      run_frame(0,  32'h0, -1, "R4 0 bits");
   endtask

   task automatic t_long_R5;
      run_frame(13, {19'h0, 1'b1, 4'd2, 8'h66}, -1, "R5 13 bits");
      // 28 edges would wrap a 4-bit counter back to 12 without saturation
      run_frame(28, {4'h0, 16'hFFFF, 4'd0, 8'h77}, -1, "R5 28 bits");
   endtask

   task automatic t_bad_addr_R6;
      run_frame(12, {20'h0, 4'd4,  8'h12}, -1, "R6 addr 4");
      run_frame(12, {20'h0, 4'd15, 8'h34}, -1, "R6 addr 15");
   endtask

   task automatic t_idle_clk_R7;
      send_bits(3, 32'h7);
      run_frame(11, {21'h0, 3'd3, 8'h99}, -1, "R7 idle edges not counted");
      send_bits(2, 32'h0);
      run_frame(12, {20'h0, 4'd3, 8'h5A}, 3, "R7 frame after idle edges");
   endtask

   task automatic t_recover_R9;
      run_frame(5, 32'h1F, -1, "R9 dropped frame");
      run_frame(12, {20'h0, 4'd0, 8'hC3}, 0, "R9 following frame");
   endtask

   initial begin
      wait_cyc(5);
      rst_n = 1'b1;
      wait_cyc(3);
      t_reset_R1();
      t_basic_R2();
      t_short_R4();
      t_long_R5();
      t_bad_addr_R6();
      t_idle_clk_R7();
      t_recover_R9();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog R1-all actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule